// File: doc/BRIEF.md
# Colour Measurement Sequencer and Result Holder

This block paces measurement cycles for a four-channel light sensor front end and holds the latest readings. A one-byte configuration word selects the integration window, chooses between continuous and on-demand operation, carries a one-shot start bit and can switch sensing off. A clock divider produces a millisecond tick, and a millisecond counter measures each window. When a window closes, the four channel counts presented by an abstract converter are captured together into result registers.

In continuous mode each cycle is followed at once by the next. In on-demand mode the controller waits until the start bit is written, runs exactly one window and then clears the bit. Shutdown stops any cycle in flight and discards it. The captured results stay on the outputs, unchanged, through idle time and shutdown, until a later cycle completes. A busy flag shows a window in progress, and a one-clock valid strobe marks each capture.

Top module: `color_meas_seq`

## Requirements
- R1: The configuration byte places the window code in bits 6:4, the start bit in bit 2, the on-demand select in bit 1 and the shutdown bit in bit 0. Bits 7 and 3 always read as zero. The byte resets to 0x00, which means continuous mode with sensing enabled.
- R2: A window code c from 0 to 5 gives a window of BASE_MS·2^c milliseconds, and codes 6 and 7 behave as code 5. Each millisecond lasts CLK_PER_MS clocks. In on-demand mode, valid rises BASE_MS·2^c·CLK_PER_MS+1 clocks after the write edge that set the start bit.
- R3: In continuous mode with sensing enabled, the next window starts in the same clock in which one ends. Busy stays high, and the valid strobes come exactly one window apart.
- R4: In on-demand mode, a write of the start bit while idle and enabled makes the start bit read 1 and starts one window one clock later. The bit clears in the clock the window completes, and no further window runs without a new write.
- R5: A start bit written while a window is running has no effect: that window keeps its length and no extra window follows. A start bit written together with continuous mode reads back as 0.
- R6: A write that sets the shutdown bit ends any window in that same clock. Busy drops, no valid strobe occurs and the results do not change. No window starts while shutdown is set.
- R7: The results change only in a clock where valid is high. They keep their values between cycles, through shutdown and through on-demand idle time.
- R8: At completion, all four results take the converter inputs present at that clock edge, in the same clock, and valid is high for exactly that one clock.
- R9: A change of the window code during a window does not alter that window. The new code applies from the next window onward.
- R10: After reset, busy and valid are low and all four results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_din | input | 8 | Configuration byte to write |
| cfg_q | output | 8 | Current configuration byte |
| conv_r | input | CH_W | Converter count, red channel |
| conv_g | input | CH_W | Converter count, green channel |
| conv_b | input | CH_W | Converter count, blue channel |
| conv_w | input | CH_W | Converter count, white channel |
| res_r | output | CH_W | Held red result |
| res_g | output | CH_W | Held green result |
| res_b | output | CH_W | Held blue result |
| res_w | output | CH_W | Held white result |
| busy | output | 1 | A window is in progress |
| res_valid | output | 1 | One-clock strobe when results are captured |

## Verification
The assertions check on every cycle that the results move only under a valid strobe, that valid lasts one clock and always ends a busy window, that a shutdown write leaves the block idle with no capture, that shutdown and busy never coincide, that the start bit is clear after an on-demand capture, and that a start bit written during a continuous window never appears. Window lengths for each code, the clamping of codes 6 and 7, the deferral of a code change to the next window, the single-shot behaviour of on-demand mode and the values captured from the converter can only be shown by the bench scenarios. In those scenarios the bench's reference model is compared with the outputs on every clock, and directed measurements count the clocks between strobes.

// File: rtl/color_meas_seq.sv
module color_meas_seq #(
  parameter int CH_W       = 16,
  parameter int CLK_PER_MS = 125000,
  parameter int BASE_MS    = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [7:0]      cfg_din,
  output logic [7:0]      cfg_q,
  input  logic [CH_W-1:0] conv_r,
  input  logic [CH_W-1:0] conv_g,
  input  logic [CH_W-1:0] conv_b,
  input  logic [CH_W-1:0] conv_w,
  output logic [CH_W-1:0] res_r,
  output logic [CH_W-1:0] res_g,
  output logic [CH_W-1:0] res_b,
  output logic [CH_W-1:0] res_w,
  output logic            busy,
  output logic            res_valid
);
  localparam int MAX_CODE = 5;
  localparam int MAX_MS   = BASE_MS << MAX_CODE;
  localparam int MS_W     = $clog2(MAX_MS + 1);
  localparam int PRE_W    = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

  logic [2:0]      it_q;
  logic            trig_q, af_q, sd_q;
  logic            busy_q, valid_q;
  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0] ms_q, win_q;
  logic [CH_W-1:0] r_q, g_q, b_q, w_q;

  logic [2:0]      it_eff;
  logic [MS_W-1:0] win_sel;
  logic            tick, done, abort, auto_go, start, reload;
  logic            unused_bits;

  assign unused_bits = cfg_din[7] ^ cfg_din[3];

  assign it_eff  = (it_q > 3'(MAX_CODE)) ? 3'(MAX_CODE) : it_q;
  assign win_sel = MS_W'(BASE_MS) << it_eff;

  assign tick    = busy_q && (pre_q == PRE_LAST);
  assign done    = tick && (ms_q == win_q - MS_W'(1));
  assign abort   = cfg_wr && cfg_din[0];
  assign auto_go = !sd_q && !af_q;
  assign start   = !busy_q && !sd_q && (!af_q || trig_q);
  assign reload  = start || (done && auto_go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      r_q     <= '0;
      g_q     <= '0;
      b_q     <= '0;
      w_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      if (abort) begin
        busy_q <= 1'b0;
      end else if (done) begin
        busy_q  <= auto_go;
        valid_q <= 1'b1;
        r_q     <= conv_r;
        g_q     <= conv_g;
        b_q     <= conv_b;
        w_q     <= conv_w;
      end else if (start) begin
        busy_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
      win_q <= '0;
    end else if (reload && !abort) begin
      pre_q <= '0;
      ms_q  <= '0;
      win_q <= win_sel;
    end else if (tick) begin
      pre_q <= '0;
      ms_q  <= ms_q + MS_W'(1);
    end else if (busy_q) begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      it_q <= 3'd0;
      af_q <= 1'b0;
      sd_q <= 1'b0;
    end else if (cfg_wr) begin
      it_q <= cfg_din[6:4];
      af_q <= cfg_din[1];
      sd_q <= cfg_din[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      trig_q <= 1'b0;
    else if (abort || done || (cfg_wr && !cfg_din[1]))
      trig_q <= 1'b0;
    else if (cfg_wr && !busy_q && cfg_din[2])
      trig_q <= 1'b1;
  end

  assign cfg_q     = {1'b0, it_q, 1'b0, trig_q, af_q, sd_q};
  assign busy      = busy_q;
  assign res_valid = valid_q;
  assign res_r     = r_q;
  assign res_g     = g_q;
  assign res_b     = b_q;
  assign res_w     = w_q;
endmodule

module color_meas_seq_chk #(
  parameter int CH_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic [7:0]      cfg_din,
  input logic [7:0]      cfg_q,
  input logic [CH_W-1:0] res_r,
  input logic [CH_W-1:0] res_g,
  input logic [CH_W-1:0] res_b,
  input logic [CH_W-1:0] res_w,
  input logic            busy,
  input logic            res_valid
);
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable({res_r, res_g, res_b, res_w})); // R7
  AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R8
  AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy)); // R8
  AST_SHUTDOWN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_din[0]) |=> (!busy && !res_valid)); // R6
  AST_SHUTDOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[0] |-> !busy); // R6
  AST_TRIG_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cfg_q[1]) |-> !cfg_q[2]); // R4
  AST_TRIG_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && busy && !cfg_q[2]) |=> !cfg_q[2]); // R5
endmodule

bind color_meas_seq color_meas_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_din(cfg_din), .cfg_q(cfg_q),
  .res_r(res_r), .res_g(res_g), .res_b(res_b), .res_w(res_w),
  .busy(busy), .res_valid(res_valid)
);

// File: tb/sim_color_meas_seq.sv
`timescale 1ns/1ps
module sim_color_meas_seq;
  localparam int CH_W = 16;
  localparam int P    = 3;
  localparam int BMS  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_din = 8'h00;
  logic [7:0] cfg_q;
  logic [CH_W-1:0] conv_r = '0, conv_g = '0, conv_b = '0, conv_w = '0;
  logic [CH_W-1:0] res_r, res_g, res_b, res_w;
  logic busy, res_valid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] cyc = 16'd0;

  always #4 clk = ~clk;

  color_meas_seq #(.CH_W(CH_W), .CLK_PER_MS(P), .BASE_MS(BMS)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_din(cfg_din), .cfg_q(cfg_q),
    .conv_r(conv_r), .conv_g(conv_g), .conv_b(conv_b), .conv_w(conv_w),
    .res_r(res_r), .res_g(res_g), .res_b(res_b), .res_w(res_w),
    .busy(busy), .res_valid(res_valid)
  );

  function automatic int win(input int c);
    int e;
    e = (c > 5) ? 5 : c;
    return BMS * (1 << e) * P;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter stimulus, changes every clock
  always @(negedge clk) begin
    cyc    <= cyc + 16'd1;
    conv_r <= cyc * 16'd7;
    conv_g <= (cyc * 16'd7) ^ 16'hA5A5;
    conv_b <= (cyc * 16'd7) + 16'd3;
    conv_w <= ~(cyc * 16'd7);
  end

  // behavioural reference model
  bit m_busy, m_valid, m_trig, m_af, m_sd;
  int m_rem;
  int m_it;
  logic [CH_W-1:0] m_res [4];

  always @(posedge clk) begin
    bit ob;
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_trig = 0; m_af = 0; m_sd = 0; m_rem = 0; m_it = 0;
      foreach (m_res[i]) m_res[i] = '0;
    end else begin
      ob = m_busy;
      m_valid = 0;
      if (cfg_wr && cfg_din[0]) m_busy = 0;
      else if (ob) begin
        m_rem--;
        if (m_rem == 0) begin
          m_res[0] = conv_r; m_res[1] = conv_g; m_res[2] = conv_b; m_res[3] = conv_w;
          m_valid = 1;
          if (!m_sd && !m_af) m_rem = win(m_it);
          else m_busy = 0;
        end
      end else if (!m_sd && (!m_af || m_trig)) begin
        m_busy = 1;
        m_rem = win(m_it);
      end
      if ((cfg_wr && cfg_din[0]) || m_valid || (cfg_wr && !cfg_din[1])) m_trig = 0;
      else if (cfg_wr && !ob && cfg_din[2]) m_trig = 1;
      if (cfg_wr) begin
        m_it = int'(cfg_din[6:4]); m_af = cfg_din[1]; m_sd = cfg_din[0];
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(cfg_q == {1'b0, 3'(m_it), 1'b0, m_trig, m_af, m_sd}, "R1 cfg_q model", cfg_q,
          {1'b0, 3'(m_it), 1'b0, m_trig, m_af, m_sd});
      chk(busy == m_busy, "R3 busy model", busy, m_busy);
      chk(res_valid == m_valid, "R8 valid model", res_valid, m_valid);
      chk(res_r == m_res[0] && res_g == m_res[1] && res_b == m_res[2] && res_w == m_res[3],
          "R7 results model", res_r, m_res[0]);
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_din = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_din = 8'h00;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!res_valid && n < 1000);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: run did not end actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int n, pulses;
    logic [CH_W-1:0] sv_r, sv_g, sv_b, sv_w;
    repeat (3) @(negedge clk);
    chk(!busy && !res_valid, "R10 reset busy/valid", {busy, res_valid}, 0);
    chk(res_r == 0 && res_g == 0 && res_b == 0 && res_w == 0, "R10 reset results", res_r, 0);
    chk(cfg_q == 8'h00, "R1 reset config", cfg_q, 0);
    rst_n = 1'b1;

    // continuous mode, code 0
    wait_pulse(n);
    wait_pulse(n);
    chk(n == win(0), "R2 window code 0", n, win(0));
    chk(busy, "R3 back-to-back busy at capture", busy, 1);
    chk(res_g == (res_r ^ 16'hA5A5) && res_b == res_r + 16'd3 && res_w == ~res_r,
        "R8 four channels same clock", res_g, res_r ^ 16'hA5A5);

    // code change mid window
    repeat (3) @(negedge clk);
    wr(8'h20);
    wait_pulse(n);
    chk(n == win(0) - 5, "R9 current window unchanged", n, win(0) - 5);
    wait_pulse(n);
    chk(n == win(2), "R9 new code next window", n, win(2));

    // shutdown abort
    repeat (4) @(negedge clk);
    sv_r = res_r; sv_g = res_g; sv_b = res_b; sv_w = res_w;
    wr(8'hD9);
    chk(cfg_q == 8'h51, "R1 reserved bits read zero", cfg_q, 8'h51);
    chk(!busy, "R6 abort drops busy", busy, 0);
    pulses = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (res_valid || busy) pulses++;
    end
    chk(pulses == 0, "R6 no activity in shutdown", pulses, 0);
    chk(res_r == sv_r && res_g == sv_g && res_b == sv_b && res_w == sv_w,
        "R7 results held across shutdown", res_r, sv_r);

    // on-demand idle
    wr(8'h12);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy) pulses++;
    end
    chk(pulses == 0, "R4 on-demand waits for start", pulses, 0);
    chk(res_r == sv_r && res_w == sv_w, "R7 results held in idle", res_r, sv_r);

    // single on-demand cycle, code 1
    wr(8'h16);
    chk(cfg_q[2] == 1'b1, "R4 start bit reads one", cfg_q[2], 1);
    wait_pulse(n);
    chk(n == win(1) + 1, "R4 one window after start", n, win(1) + 1);
    chk(cfg_q[2] == 1'b0, "R4 start bit self-clears", cfg_q[2], 0);
    pulses = 0;
    for (int i = 0; i < 2 * win(1); i++) begin
      @(negedge clk);
      if (res_valid || busy) pulses++;
    end
    chk(pulses == 0, "R4 no repeat without write", pulses, 0);

    // start bit during a running window
    wr(8'h16);
    repeat (5) @(negedge clk);
    wr(8'h06);
    pulses = 0;
    n = 0;
    for (int i = 0; i < 3 * win(1); i++) begin
      @(negedge clk);
      if (res_valid) begin pulses++; n = i; end
    end
    chk(pulses == 1, "R5 start while busy ignored", pulses, 1);
    chk(n == win(1) - 7, "R5 window length kept", n, win(1) - 7);

    // clamped codes
    wr(8'h76);
    wait_pulse(n);
    chk(n == win(5) + 1, "R2 code 7 clamps to code 5", n, win(5) + 1);
    wr(8'h66);
    wait_pulse(n);
    chk(n == win(5) + 1, "R2 code 6 clamps to code 5", n, win(5) + 1);

    // start bit in continuous mode
    wr(8'h04);
    chk(cfg_q[2] == 1'b0, "R5 start bit ignored in continuous mode", cfg_q[2], 0);
    wait_pulse(n);
    wait_pulse(n);
    chk(n == win(0), "R3 continuous resumes", n, win(0));

    repeat (2) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule